// File: doc/BRIEF.md
# USB Device Interrupt Status Controller

This block collects the event pulses produced by a USB device's serial engine and endpoint logic and keeps them as latched status bits in two 8-bit status registers. Two enable registers select which of those bits raise the single interrupt line to the CPU. The CPU reads the registers and writes them through a small register port.

Endpoint and bus-power status bits are cleared by writing 1, so software can read a status register and write the same value back to acknowledge everything it has seen. The bus-reset status bit works the other way: software clears it by writing 0. A USB bus reset returns every status and enable bit and the suspend mode flag to their defaults, but sets the bus-reset bit itself.

Suspend and resume share one enable bit. A resume is recorded only while the device is in suspend mode.

Top module: `usb_irq_ctrl`

## Requirements
- R1: Status register 1 bit 0 (endpoint 0) sets on any of these pulses: `ep0_xfer_done`, `ep0_setup_end`, `ep0_stall` or `ep0_data_end_clr`.
- R2: The OUT bit of data endpoint n (n = 1..4) sets on `ep_out_rx_done`, `ep_out_stall` or `ep_out_overrun` bit n-1. OUT bits 1 to 3 sit in status register 1 bits 5 to 7. OUT bit 4 sits in status register 2 bit 0.
- R3: The IN bit of data endpoint n sets on `ep_in_tx_done` or `ep_in_underrun` bit n-1. These bits sit in status register 1 bits 1 to 4.
- R4: For endpoint, suspend and resume bits, writing 1 clears the bit and writing 0 leaves it unchanged. Writing back a value just read clears every set bit in that value.
- R5: A write to status register 1 changes only status register 1. Clearing register 1 and then register 2 leaves both clear.
- R6: Status register 2 bit 5 sets on `usb_suspend`, which also enters suspend mode. Bit 6 sets on `usb_resume` only while in suspend mode. Resume and bus reset both leave suspend mode.
- R7: After a `usb_reset` pulse, status register 2 bit 7 reads 1. All other status bits, both enable registers and the suspend mode flag return to 0.
- R8: Writing 0 to status register 2 bit 7 clears the bus-reset bit. Writing 1 to it leaves the bit at 1.
- R9: If an event and a CPU clear of the same bit fall in the same cycle, the bit ends up 1.
- R10: `irq_o` is high when any status bit is 1 and its enable is also 1. Status bit k of register 1 is gated by enable register 1 bit k. Status register 2 bit 0 is gated by enable register 2 bit 0. Enable register 2 bit 7 gates both suspend and resume. The bus-reset bit is always enabled.
- R11: The register map is: address 0 is status 1, address 1 is status 2, address 2 is enable 1 and address 3 is enable 2. Enable register 2 implements only bits 0 and 7. Status register 2 bits 1 to 4 and all other unimplemented bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ep0_xfer_done | input | 1 | Endpoint 0 packet received or sent |
| ep0_setup_end | input | 1 | Endpoint 0 setup-end asserted |
| ep0_stall | input | 1 | Endpoint 0 forced stall asserted |
| ep0_data_end_clr | input | 1 | Endpoint 0 data-end flag cleared |
| ep_out_rx_done | input | 4 | OUT packet received, one bit per data endpoint |
| ep_out_stall | input | 4 | OUT forced stall asserted |
| ep_out_overrun | input | 4 | OUT overrun asserted |
| ep_in_tx_done | input | 4 | IN packet sent |
| ep_in_underrun | input | 4 | IN underrun asserted |
| usb_suspend | input | 1 | Suspend signalling detected |
| usb_resume | input | 1 | Resume signalling detected |
| usb_reset | input | 1 | Bus reset detected |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions check on every cycle that a bus reset leaves only the reset bit set and wipes the enables (R7). They also check that a pending event beats a same-cycle clear (R9), that a resume bit can rise only out of suspend mode (R6), and that an all-zero write to status register 1 drops no bit (R4). The bench scenarios cover the rest:
- the mapping of each event to its register bit position,
- the write-back clearing order across the two registers,
- the write-0 clear of the reset bit,
- the masking of the interrupt line under different enable settings, including the shared suspend/resume enable.

// File: rtl/usb_irq_pkg.sv
// Package: shared sizes, bit indices and register addresses for the USB
// interrupt status controller. Assumes four data endpoints and 8-bit registers.
package usb_irq_pkg;
    localparam int REG_W       = 8;
    localparam int NUM_EP      = 4;
    localparam int ADDR_W      = 2;
    // endpoint bits: EP0, then NUM_EP IN bits, then NUM_EP OUT bits
    localparam int EP_BITS     = 1 + 2 * NUM_EP;
    localparam int S2_EP_BITS  = EP_BITS - REG_W;
    localparam int IDX_EP0     = 0;
    localparam int IDX_IN0     = 1;
    localparam int IDX_OUT0    = 1 + NUM_EP;
    localparam int IDX_SUSP    = EP_BITS;
    localparam int IDX_RES     = EP_BITS + 1;
    localparam int IDX_RST     = EP_BITS + 2;
    localparam int NUM_ST      = EP_BITS + 3;
    // bit positions inside status/enable register 2
    localparam int S2_SUSP     = 5;
    localparam int S2_RES      = 6;
    localparam int S2_RST      = 7;
    localparam int E2_BUS      = 7;

    typedef enum logic [ADDR_W-1:0] {
        ADR_STAT1 = 2'd0,
        ADR_STAT2 = 2'd1,
        ADR_EN1   = 2'd2,
        ADR_EN2   = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/usb_irq_event_map.sv
// Module: combines the raw endpoint event pulses into one set request per
// endpoint status bit. Purely combinational; assumes one-cycle pulses.
module usb_irq_event_map
    import usb_irq_pkg::*;
(
    input  logic              ep0_xfer_done,
    input  logic              ep0_setup_end,
    input  logic              ep0_stall,
    input  logic              ep0_data_end_clr,
    input  logic [NUM_EP-1:0] ep_out_rx_done,
    input  logic [NUM_EP-1:0] ep_out_stall,
    input  logic [NUM_EP-1:0] ep_out_overrun,
    input  logic [NUM_EP-1:0] ep_in_tx_done,
    input  logic [NUM_EP-1:0] ep_in_underrun,
    output logic [EP_BITS-1:0] ep_set
);
    // control endpoint: any of its four conditions
    always_comb begin
        ep_set[IDX_EP0] = ep0_xfer_done | ep0_setup_end | ep0_stall | ep0_data_end_clr;
    end

    // data endpoints: one IN and one OUT set request each
    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        assign ep_set[IDX_IN0 + g]  = ep_in_tx_done[g] | ep_in_underrun[g];
        assign ep_set[IDX_OUT0 + g] = ep_out_rx_done[g] | ep_out_stall[g] | ep_out_overrun[g];
    end
endmodule

// File: rtl/usb_irq_status.sv
// Module: the latched status bits and the suspend mode flag.
// Endpoint/suspend/resume bits are write-1-to-clear, the reset bit is
// write-0-to-clear, a set beats a same-cycle clear, and a bus reset wipes
// everything except the reset bit, which it sets.
module usb_irq_status
    import usb_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [EP_BITS-1:0] ep_set,
    input  logic               usb_suspend,
    input  logic               usb_resume,
    input  logic               usb_reset,
    input  logic               wr_stat1,
    input  logic               wr_stat2,
    input  logic [REG_W-1:0]   wdata,
    output logic [NUM_ST-1:0]  status
);
    logic [NUM_ST-1:0] set_vec;
    logic [NUM_ST-1:0] clr_vec;
    logic              susp_mode;

    // gather set requests; resume counts only while suspended
    always_comb begin
        set_vec           = '0;
        set_vec[EP_BITS-1:0] = ep_set;
        set_vec[IDX_SUSP] = usb_suspend;
        set_vec[IDX_RES]  = usb_resume & susp_mode;
        set_vec[IDX_RST]  = usb_reset;
    end

    // turn CPU writes into per-bit clear requests
    always_comb begin
        clr_vec = '0;
        if (wr_stat1) begin
            clr_vec[REG_W-1:0] = wdata;
        end
        if (wr_stat2) begin
            clr_vec[EP_BITS-1:REG_W] = wdata[S2_EP_BITS-1:0];
            clr_vec[IDX_SUSP]        = wdata[S2_SUSP];
            clr_vec[IDX_RES]         = wdata[S2_RES];
            clr_vec[IDX_RST]         = ~wdata[S2_RST];
        end
    end

    // status register update with bus-reset wipe and set priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else if (usb_reset) begin
            status          <= '0;
            status[IDX_RST] <= 1'b1;
        end else begin
            status <= set_vec | (status & ~clr_vec);
        end
    end

    // suspend mode tracking: enter on suspend, leave on resume or reset
    always_ff @(posedge clk) begin
        if (!rst_n || usb_reset) begin
            susp_mode <= 1'b0;
        end else if (usb_resume) begin
            susp_mode <= 1'b0;
        end else if (usb_suspend) begin
            susp_mode <= 1'b1;
        end
    end

    AST_RST_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        usb_reset |=> status[IDX_RST]); // R7
    AST_RST_WIPES_REST: assert property (@(posedge clk) disable iff (!rst_n)
        usb_reset |=> (status[IDX_RST-1:0] == '0)); // R7
    AST_RESUME_NEEDS_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[IDX_RES]) |-> $past(susp_mode)); // R6
    AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat1 && wdata == '0 && !usb_reset) |=>
        ((status[REG_W-1:0] & $past(status[REG_W-1:0])) == $past(status[REG_W-1:0]))); // R4
    for (genvar g = 0; g < IDX_RST; g++) begin : g_chk
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (set_vec[g] && !usb_reset) |=> status[g]); // R9
    end
endmodule

// File: rtl/usb_irq_enable.sv
// Module: the two enable registers. Enable 1 and bit 0 of enable 2 gate the
// endpoint bits one for one; bit 7 of enable 2 gates suspend and resume.
// The reset bit is always enabled. A bus reset returns all enables to 0.
module usb_irq_enable
    import usb_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usb_reset,
    input  logic              wr_en1,
    input  logic              wr_en2,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  en1_rd,
    output logic [REG_W-1:0]  en2_rd,
    output logic [NUM_ST-1:0] en_vec
);
    logic [EP_BITS-1:0] en_ep;
    logic               en_bus;

    // enable register storage, cleared by either reset
    always_ff @(posedge clk) begin
        if (!rst_n || usb_reset) begin
            en_ep  <= '0;
            en_bus <= 1'b0;
        end else begin
            if (wr_en1) en_ep[REG_W-1:0] <= wdata;
            if (wr_en2) begin
                en_ep[EP_BITS-1:REG_W] <= wdata[S2_EP_BITS-1:0];
                en_bus                 <= wdata[E2_BUS];
            end
        end
    end

    // read-back views and the per-status-bit enable vector
    always_comb begin
        en1_rd                   = en_ep[REG_W-1:0];
        en2_rd                   = '0;
        en2_rd[S2_EP_BITS-1:0]   = en_ep[EP_BITS-1:REG_W];
        en2_rd[E2_BUS]           = en_bus;
        en_vec                   = '0;
        en_vec[EP_BITS-1:0]      = en_ep;
        en_vec[IDX_SUSP]         = en_bus;
        en_vec[IDX_RES]          = en_bus;
        en_vec[IDX_RST]          = 1'b1;
    end

    AST_EN_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
        usb_reset |=> (en_ep == '0 && !en_bus)); // R7
endmodule

// File: rtl/usb_irq_ctrl.sv
// Module: top of the USB interrupt status controller. Decodes the CPU
// register port, muxes read data and forms the combined interrupt line.
// Assumes single-cycle write strobes and event pulses synchronous to clk.
module usb_irq_ctrl
    import usb_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ep0_xfer_done,
    input  logic              ep0_setup_end,
    input  logic              ep0_stall,
    input  logic              ep0_data_end_clr,
    input  logic [NUM_EP-1:0] ep_out_rx_done,
    input  logic [NUM_EP-1:0] ep_out_stall,
    input  logic [NUM_EP-1:0] ep_out_overrun,
    input  logic [NUM_EP-1:0] ep_in_tx_done,
    input  logic [NUM_EP-1:0] ep_in_underrun,
    input  logic              usb_suspend,
    input  logic              usb_resume,
    input  logic              usb_reset,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq_o
);
    logic [EP_BITS-1:0] ep_set;
    logic [NUM_ST-1:0]  status;
    logic [NUM_ST-1:0]  en_vec;
    logic [REG_W-1:0]   en1_rd;
    logic [REG_W-1:0]   en2_rd;
    logic [REG_W-1:0]   stat2_rd;
    logic               wr_stat1, wr_stat2, wr_en1, wr_en2;

    // write strobe decode per register
    always_comb begin
        wr_stat1 = reg_wr && (reg_addr == ADR_STAT1);
        wr_stat2 = reg_wr && (reg_addr == ADR_STAT2);
        wr_en1   = reg_wr && (reg_addr == ADR_EN1);
        wr_en2   = reg_wr && (reg_addr == ADR_EN2);
    end

    usb_irq_event_map u_map (
        .ep0_xfer_done    (ep0_xfer_done),
        .ep0_setup_end    (ep0_setup_end),
        .ep0_stall        (ep0_stall),
        .ep0_data_end_clr (ep0_data_end_clr),
        .ep_out_rx_done   (ep_out_rx_done),
        .ep_out_stall     (ep_out_stall),
        .ep_out_overrun   (ep_out_overrun),
        .ep_in_tx_done    (ep_in_tx_done),
        .ep_in_underrun   (ep_in_underrun),
        .ep_set           (ep_set)
    );

    usb_irq_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .ep_set      (ep_set),
        .usb_suspend (usb_suspend),
        .usb_resume  (usb_resume),
        .usb_reset   (usb_reset),
        .wr_stat1    (wr_stat1),
        .wr_stat2    (wr_stat2),
        .wdata       (reg_wdata),
        .status      (status)
    );

    usb_irq_enable u_enable (
        .clk       (clk),
        .rst_n     (rst_n),
        .usb_reset (usb_reset),
        .wr_en1    (wr_en1),
        .wr_en2    (wr_en2),
        .wdata     (reg_wdata),
        .en1_rd    (en1_rd),
        .en2_rd    (en2_rd),
        .en_vec    (en_vec)
    );

    // status register 2 read view
    always_comb begin
        stat2_rd                 = '0;
        stat2_rd[S2_EP_BITS-1:0] = status[EP_BITS-1:REG_W];
        stat2_rd[S2_SUSP]        = status[IDX_SUSP];
        stat2_rd[S2_RES]         = status[IDX_RES];
        stat2_rd[S2_RST]         = status[IDX_RST];
    end

    // read data mux by address
    always_comb begin
        unique case (reg_addr)
            ADR_STAT1: reg_rdata = status[REG_W-1:0];
            ADR_STAT2: reg_rdata = stat2_rd;
            ADR_EN1:   reg_rdata = en1_rd;
            default:   reg_rdata = en2_rd;
        endcase
    end

    // combined interrupt request
    assign irq_o = |(status & en_vec);
endmodule

// File: tb/usb_irq_ctrl_tb.sv
`timescale 1ns/1ps
module usb_irq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ep0_xfer_done = 0, ep0_setup_end = 0, ep0_stall = 0, ep0_data_end_clr = 0;
    logic [3:0] ep_out_rx_done = '0, ep_out_stall = '0, ep_out_overrun = '0;
    logic [3:0] ep_in_tx_done = '0, ep_in_underrun = '0;
    logic       usb_suspend = 0, usb_resume = 0, usb_reset = 0;
    logic       reg_wr = 0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [1:0] a;
        logic [7:0] d;
        logic       irq;
        string      tag;
    } exp_t;
    exp_t exp_q[$];
    exp_t cur;

    always #2 clk = ~clk;

    usb_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .ep0_xfer_done(ep0_xfer_done), .ep0_setup_end(ep0_setup_end),
        .ep0_stall(ep0_stall), .ep0_data_end_clr(ep0_data_end_clr),
        .ep_out_rx_done(ep_out_rx_done), .ep_out_stall(ep_out_stall),
        .ep_out_overrun(ep_out_overrun), .ep_in_tx_done(ep_in_tx_done),
        .ep_in_underrun(ep_in_underrun), .usb_suspend(usb_suspend),
        .usb_resume(usb_resume), .usb_reset(usb_reset),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    // monitor: pops expected items and compares mid-cycle
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            checks++;
            if (reg_rdata !== cur.d || irq_o !== cur.irq) begin
                errors++;
                $display("FAIL %s addr=%0d actual rdata=%02h irq=%b expected rdata=%02h irq=%b",
                         cur.tag, cur.a, reg_rdata, irq_o, cur.d, cur.irq);
            end
        end
    end

    task automatic chk(input logic [1:0] a, input logic [7:0] d, input logic irq, input string tag);
        exp_t e;
        @(negedge clk);
        reg_addr = a;
        e.a = a; e.d = d; e.irq = irq; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic drop_all();
        ep0_xfer_done = 0; ep0_setup_end = 0; ep0_stall = 0; ep0_data_end_clr = 0;
        ep_out_rx_done = '0; ep_out_stall = '0; ep_out_overrun = '0;
        ep_in_tx_done = '0; ep_in_underrun = '0;
        usb_suspend = 0; usb_resume = 0; usb_reset = 0;
    endtask

    // pulse selector: 0..3 ep0 events, 4 suspend, 5 resume, 6 bus reset
    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: ep0_xfer_done = 1;
            1: ep0_setup_end = 1;
            2: ep0_stall = 1;
            3: ep0_data_end_clr = 1;
            4: usb_suspend = 1;
            5: usb_resume = 1;
            default: usb_reset = 1;
        endcase
        @(negedge clk);
        drop_all();
    endtask

    task automatic pulse_ep(input int kind, input int ep);
        @(negedge clk);
        case (kind)
            0: ep_out_rx_done[ep] = 1;
            1: ep_out_stall[ep] = 1;
            2: ep_out_overrun[ep] = 1;
            3: ep_in_tx_done[ep] = 1;
            default: ep_in_underrun[ep] = 1;
        endcase
        @(negedge clk);
        drop_all();
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // reset state, R11
        chk(0, 8'h00, 0, "R11 stat1 reset");
        chk(1, 8'h00, 0, "R11 stat2 reset");
        chk(2, 8'h00, 0, "R11 en1 reset");
        chk(3, 8'h00, 0, "R11 en2 reset");
        // R1: each endpoint 0 condition
        for (int k = 0; k < 4; k++) begin
            pulse(k);
            chk(0, 8'h01, 0, "R1 ep0 set");
            wr(0, 8'h01);
            chk(0, 8'h00, 0, "R4 ep0 w1c");
        end
        // R2: OUT bits
        pulse_ep(0, 0);
        chk(0, 8'h20, 0, "R2 out1 rx");
        pulse_ep(1, 2);
        chk(0, 8'hA0, 0, "R2 out3 stall");
        pulse_ep(2, 3);
        chk(1, 8'h01, 0, "R2 out4 overrun");
        // R3: IN bits
        pulse_ep(3, 1);
        chk(0, 8'hA4, 0, "R3 in2 tx");
        pulse_ep(4, 3);
        chk(0, 8'hB4, 0, "R3 in4 underrun");
        // R4: zero write keeps, write-back clears
        wr(0, 8'h00);
        chk(0, 8'hB4, 0, "R4 zero write keeps");
        wr(0, 8'hB4);
        chk(0, 8'h00, 0, "R4 write-back clears");
        // R5: register 2 untouched by register 1 write, then cleared
        chk(1, 8'h01, 0, "R5 stat2 kept after stat1 write");
        wr(1, 8'h01);
        chk(1, 8'h00, 0, "R5 stat2 cleared second");
        // R10: enable gating of an endpoint bit
        wr(2, 8'h02);
        chk(2, 8'h02, 0, "R11 en1 readback");
        pulse_ep(3, 0);
        chk(0, 8'h02, 1, "R10 enabled in1 raises irq");
        wr(0, 8'h02);
        chk(0, 8'h00, 0, "R10 irq drops after clear");
        wr(3, 8'hFF);
        chk(3, 8'h81, 0, "R11 en2 implemented bits");
        // R6: resume ignored when not suspended
        pulse(5);
        chk(1, 8'h00, 0, "R6 resume ignored awake");
        pulse(4);
        chk(1, 8'h20, 1, "R6 R10 suspend set and enabled");
        wr(1, 8'h20);
        chk(1, 8'h00, 0, "R4 suspend w1c");
        pulse(5);
        chk(1, 8'h40, 1, "R6 R10 resume while suspended");
        wr(1, 8'h40);
        pulse(5);
        chk(1, 8'h00, 0, "R6 resume after leaving suspend");
        // R10: shared enable off masks suspend
        wr(3, 8'h00);
        pulse(4);
        chk(1, 8'h20, 0, "R10 suspend masked");
        // R9: set beats same-cycle clear
        @(negedge clk);
        ep_out_rx_done[1] = 1;
        reg_wr = 1; reg_addr = 0; reg_wdata = 8'h40;
        @(negedge clk);
        drop_all(); reg_wr = 0; reg_wdata = '0;
        chk(0, 8'h40, 0, "R9 set wins");
        // R7: bus reset wipe
        pulse(6);
        chk(0, 8'h00, 1, "R7 stat1 wiped");
        chk(1, 8'h80, 1, "R7 reset bit set");
        chk(2, 8'h00, 1, "R7 en1 wiped");
        chk(3, 8'h00, 1, "R7 en2 wiped");
        pulse(5);
        chk(1, 8'h80, 1, "R7 R6 suspend mode left on reset");
        // R8: write-0 clear of reset bit
        wr(1, 8'h80);
        chk(1, 8'h80, 1, "R8 write 1 keeps reset bit");
        wr(1, 8'h00);
        chk(1, 8'h00, 0, "R8 write 0 clears reset bit");
        repeat (3) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule